// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. An asynchronous start line is brought into the conversion clock domain, and its rising edge launches a binary search. The search works from the most significant bit down. Each step presents a trial code to an external DAC, waits one clock for the external comparator, and then keeps or drops that trial bit based on the comparator's single decision bit.

While a search runs, an active-low busy line is held low. When the search ends, the finished code is latched into a result register. A host reads that register over a three-state data bus gated by active-low chip-select and read strobes. A run/save mode input parks the sequencer in a quiet low-power idle state when it is low.

Top module: `sar_seq_top`

## Requirements
- R1: After synchronous reset, `busy_n` is 1, `trial_code` is 0, the result register is 0, and the bus is released (`data_oe` = 0).
- R2: `start_async` passes through a two-flop synchroniser, and a conversion begins on its rising edge only. With `start_async` raised between clock edges, `busy_n` is still 1 after the second rising clock edge and is 0 after the third. A start level that stays high launches no further conversion.
- R3: `busy_n` stays low for exactly 24 clock cycles per conversion (2 per bit), which is within a budget of 30 cycles.
- R4: The first trial code of a conversion is 12'h800 (MSB only). Each trial bit is kept when `cmp_ge` = 1 (input ≥ DAC) and cleared otherwise. With an ideal comparator, the result equals the input code.
- R5: A start rising edge that arrives while a conversion is running is ignored. That conversion's length and result are unaffected, and no new conversion follows it.
- R6: The bus truth table is as follows. With `cs_n` = 1, or with `cs_n` = 0 and `rd_n` = 1, the bus is high-impedance and `data_oe` = 0. With `cs_n` = 0 and `rd_n` = 0, `data_oe` = 1 and `data_bus` carries the result register.
- R7: The result register is loaded only at the end of a conversion. The previous result stays readable while a conversion runs.
- R8: While `mode_run` = 0 (power save), `busy_n` stays 1, `trial_code` is 0, and start edges are ignored.
- R9: Dropping `mode_run` during a conversion aborts it. On the next clock edge `busy_n` returns to 1 and `trial_code` to 0, and the result register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_async | input | 1 | Asynchronous convert-start, rising-edge active |
| mode_run | input | 1 | 1 = normal operation, 0 = power save |
| cmp_ge | input | 1 | Comparator decision: 1 when analog input ≥ DAC level |
| trial_code | output | 12 | Trial code driven to the external DAC |
| busy_n | output | 1 | Active-low conversion-in-progress flag |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| data_oe | output | 1 | High while the data bus is being driven |
| data_bus | output | 12 | Three-state result bus |

## Verification
On every cycle, the assertions check four things: the busy window never reaches the cycle budget, every conversion opens with an MSB-only trial, a driven bus always carries the result register, and the result register changes only on a busy rising edge. They also check that power save holds the sequencer idle and that a qualified start edge drops busy on the next edge. Other behaviour can only be shown by the bench's scenarios. This covers exact convergence onto a target code through an ideal comparator model, and the exact 24-cycle length. It also covers the rejection of a mid-conversion start edge and of a held-high start level, the abort path, and the readability of the old result during a new search.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // STAGES flops of synchroniser plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int WIDTH        = 12,
  parameter int CYCLE_BUDGET = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_run,
  input  logic             start_rise,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result_q,
  output logic             busy_n
);
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int CNTW = $clog2(CYCLE_BUDGET + 1) + 1;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_t       state;
  logic [IDXW-1:0]  bit_idx;
  logic [WIDTH-1:0] bit_mask;
  logic [WIDTH-1:0] kept_code;

  always_comb begin
    bit_mask  = '0;
    bit_mask[bit_idx] = 1'b1;
    kept_code = cmp_ge ? trial_code : (trial_code & ~bit_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_idx    <= '0;
      trial_code <= '0;
      result_q   <= '0;
      busy_n     <= 1'b1;
    end else if (!mode_run) begin
      state      <= ST_IDLE;
      trial_code <= '0;
      busy_n     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_rise) begin
            trial_code <= MSB_ONLY;
            bit_idx    <= IDXW'(WIDTH - 1);
            busy_n     <= 1'b0;
            state      <= ST_SETTLE;
          end
        end
        ST_SETTLE: state <= ST_DECIDE;
        ST_DECIDE: begin
          if (bit_idx == '0) begin
            trial_code <= kept_code;
            result_q   <= kept_code;
            busy_n     <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            trial_code <= kept_code | (bit_mask >> 1);
            bit_idx    <= bit_idx - 1'b1;
            state      <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Busy-window length monitor for the cycle budget
  logic [CNTW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || busy_n) busy_cnt <= '0;
    else               busy_cnt <= busy_cnt + 1'b1;
  end

  p_budget_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> (busy_cnt < CNTW'(CYCLE_BUDGET)));

  p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> (trial_code == MSB_ONLY));

  p_result_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> $rose(busy_n));

  p_psave_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_run |=> (busy_n && trial_code == '0));
endmodule

// File: rtl/sar_bus_port.sv
module sar_bus_port #(
  parameter int WIDTH = 12
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [WIDTH-1:0] result_q,
  output logic             data_oe,
  output logic [WIDTH-1:0] data_bus
);
  assign data_oe  = ~cs_n & ~rd_n;
  assign data_bus = data_oe ? result_q : 'z;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int WIDTH        = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int CYCLE_BUDGET = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_async,
  input  logic             mode_run,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy_n,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic             data_oe,
  output logic [WIDTH-1:0] data_bus
);
  logic             start_rise;
  logic [WIDTH-1:0] result_q;

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (start_async),
    .rise     (start_rise)
  );

  sar_engine #(.WIDTH(WIDTH), .CYCLE_BUDGET(CYCLE_BUDGET)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .mode_run   (mode_run),
    .start_rise (start_rise),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .result_q   (result_q),
    .busy_n     (busy_n)
  );

  sar_bus_port #(.WIDTH(WIDTH)) u_bus (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .result_q (result_q),
    .data_oe  (data_oe),
    .data_bus (data_bus)
  );

  p_start_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start_rise && mode_run && busy_n) |=> !busy_n);

  p_bus_value_r6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_bus == result_q));
endmodule

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_async = 1'b0;
  logic        mode_run = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [11:0] target = 12'h000;
  logic        cmp_ge;
  logic [11:0] trial_code;
  logic        busy_n;
  logic        data_oe;
  logic [11:0] data_bus;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  // Ideal comparator model against the target code
  assign cmp_ge = (target >= trial_code);

  sar_seq_top u0 (
    .clk(clk), .rst(rst), .start_async(start_async), .mode_run(mode_run),
    .cmp_ge(cmp_ge), .trial_code(trial_code), .busy_n(busy_n),
    .cs_n(cs_n), .rd_n(rd_n), .data_oe(data_oe), .data_bus(data_bus)
  );

  localparam logic [11:0] VEC [8] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                      12'h555, 12'hAAA, 12'h001, 12'h123};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic read_bus(output logic [11:0] val, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    val = data_bus; oe = data_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  // One conversion; optional extra start edge mid-way (R5)
  task automatic conv(input logic [11:0] tgt, input bit retrig);
    int n;
    logic [11:0] v;
    logic oe;
    target = tgt;
    @(negedge clk); start_async = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(busy_n == 1'b1, "R2 busy before sync", busy_n, 1);
    @(posedge clk); #1;
    chk(busy_n == 1'b0, "R2 busy fall", busy_n, 0);
    chk(trial_code == 12'h800, "R4 first trial", trial_code, 12'h800);
    n = 0;
    while (!busy_n && n < 40) begin
      @(posedge clk); #1;
      n++;
      if (retrig && n == 4) start_async = 1'b0;
      if (retrig && n == 8) start_async = 1'b1;
    end
    chk(n == 24, retrig ? "R5 length with extra edge" : "R3 busy length", n, 24);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      chk(busy_n == 1'b1, retrig ? "R5 no follow-on conversion" : "R2 level no retrigger", busy_n, 1);
    end
    @(negedge clk); start_async = 1'b0;
    read_bus(v, oe);
    chk(oe == 1'b1, "R6 bus driven", oe, 1);
    chk(v == tgt, retrig ? "R5 result" : "R4 result", v, tgt);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_checks++;
    $display("FAIL R3 watchdog expired got 1 exp 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [11:0] v;
    logic oe;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
    chk(trial_code == 12'h000, "R1 trial", trial_code, 0);
    chk(data_oe == 1'b0, "R1 bus released", data_oe, 0);
    read_bus(v, oe);
    chk(v == 12'h000, "R1 result zero", v, 0);

    // R6 truth table
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(data_oe == 1'b0, "R6 cs low rd high", data_oe, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(data_oe == 1'b0, "R6 cs high rd low", data_oe, 0);
    rd_n = 1'b1;

    // Vector table: R2 R3 R4
    for (int i = 0; i < 8; i++) conv(VEC[i], 1'b0);

    // R5 extra start edge while busy
    conv(12'h3C5, 1'b1);

    // R7 old result readable mid-conversion
    target = 12'h9E1;
    @(negedge clk); start_async = 1'b1;
    repeat (10) @(posedge clk);
    read_bus(v, oe);
    chk(v == 12'h3C5, "R7 old result during conversion", v, 12'h3C5);
    chk(busy_n == 1'b0, "R7 still busy", busy_n, 0);
    repeat (30) @(posedge clk);
    @(negedge clk); start_async = 1'b0;
    read_bus(v, oe);
    chk(v == 12'h9E1, "R7 new result after end", v, 12'h9E1);

    // R9 abort by mode low
    target = 12'h0F0;
    @(negedge clk); start_async = 1'b1;
    repeat (9) @(posedge clk);
    #1 chk(busy_n == 1'b0, "R9 busy before abort", busy_n, 0);
    @(negedge clk); mode_run = 1'b0;
    @(posedge clk); #1;
    chk(busy_n == 1'b1, "R9 busy released", busy_n, 1);
    chk(trial_code == 12'h000, "R9 trial cleared", trial_code, 0);
    read_bus(v, oe);
    chk(v == 12'h9E1, "R9 result kept", v, 12'h9E1);

    // R8 power save ignores start
    @(negedge clk); start_async = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); start_async = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      chk(busy_n == 1'b1 && trial_code == 12'h000, "R8 power save idle",
          {busy_n, trial_code}, 13'h1000);
    end
    @(negedge clk); start_async = 1'b0; mode_run = 1'b1;
    repeat (4) @(posedge clk);
    conv(12'h456, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule